// File: doc/BRIEF.md
# Timebase Prescaler Clock-Source Selector

This block decides when a timebase prescaler advances. A 3-bit source code picks where the advance pulses come from. The choices are a divide-by-8 enable gated by the level of an external pin, the rising, falling or both edges of that pin, a free-running divide-by-8 enable, or nothing at all.

When the angle-mode flag is set, the block does not advance the timebase. Instead, the edge codes name which pin transitions are reported as tooth-detect events for external angle-tracking logic. The pin level arrives already synchronised and filtered.

Each selected advance pulse becomes a one-cycle prescaler strobe. An internal prescaler counts these strobes and emits one counter strobe every `div_val` strobes. The source code and the angle flag are registered before use, so a change takes effect on the cycle after the edge that samples it.

Top module: `tbase_src_sel`

## Requirements
- R1: During reset all three strobes are low and the registered source code holds 001 (rising edge). Once reset ends, the code is reloaded from `src_code` on every clock.
- R2: With code 000 and angle mode off, `pre_tick` pulses only on divide-by-8 enable cycles during which `ext_lvl` is high. The divide-by-8 enable fires in the cycle where its 3-bit counter, cleared by reset, holds 7.
- R3: With angle mode off, code 001 pulses `pre_tick` for each rising transition of `ext_lvl`. Code 010 pulses it for each falling transition, and code 011 for either transition.
- R4: With code 100 and angle mode off, `pre_tick` pulses once every 8 cycles whatever the pin does. Any 80-cycle window holds exactly 10 pulses.
- R5: Codes 101, 110 and 111 with angle mode off produce no `pre_tick`.
- R6: With angle mode on, `pre_tick` stays low. Codes 001, 010 and 011 pulse `tooth_tick` on rising, falling or both pin transitions respectively.
- R7: `tooth_tick` never pulses when angle mode is off. It also never pulses in angle mode under codes 000, 100, 101, 110 or 111.
- R8: `cnt_tick` pulses on the cycle after the `pre_tick` that completes a group of `div_val` strobes, and the prescaler count then restarts at zero. A `div_val` of 0 or 1 passes every strobe.
- R9: Each strobe lasts one cycle and appears on the cycle after the clock edge that first samples the pin change. A pin held steady after a transition yields no further edge strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 1 | Filtered external clock pin level |
| src_code | input | 3 | Advance-source selection code |
| angle_en | input | 1 | Angle-mode flag |
| div_val | input | PS_W | Prescaler divide value |
| pre_tick | output | 1 | Prescaler increment strobe |
| cnt_tick | output | 1 | Counter increment strobe after the prescaler |
| tooth_tick | output | 1 | Tooth-detect strobe in angle mode |

## Verification
In gated mode 000, a divide-by-8 enable cycle can coincide with a pin transition. The pin level on that exact cycle then decides whether the strobe appears. The bench provokes this by toggling the pin randomly under code 000, so falls and rises land on enable cycles. Each cycle is judged against a reference model that derives the expected strobe from its own divide counter and the sampled pin level.

Separately, a prescaler wrap (`cnt_tick`) can coincide with a new `pre_tick`. Running with small divide values makes both strobes high together, and the model checks both on every cycle.

// File: rtl/tbase_sel_pkg.sv
package tbase_sel_pkg;

    typedef enum logic [2:0] {
        SRC_GATED_DIV8 = 3'b000,
        SRC_PIN_RISE   = 3'b001,
        SRC_PIN_FALL   = 3'b010,
        SRC_PIN_BOTH   = 3'b011,
        SRC_FREE_DIV8  = 3'b100,
        SRC_RSV_A      = 3'b101,
        SRC_RSV_B      = 3'b110,
        SRC_HALT       = 3'b111
    } src_code_e;

    localparam src_code_e SRC_RESET = SRC_PIN_RISE;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_evt_t;

    // Timebase advance request for the non-angle interpretation of a code.
    function automatic logic pick_advance(src_code_e c, logic div_en,
                                          logic lvl, pin_evt_t e);
        logic r;
        case (c)
            SRC_GATED_DIV8: r = div_en & lvl;
            SRC_PIN_RISE:   r = e.rise;
            SRC_PIN_FALL:   r = e.fall;
            SRC_PIN_BOTH:   r = e.rise | e.fall;
            SRC_FREE_DIV8:  r = div_en;
            default:        r = 1'b0;
        endcase
        return r;
    endfunction

    // Tooth event for the angle-mode interpretation of a code.
    function automatic logic pick_tooth(src_code_e c, pin_evt_t e);
        logic r;
        case (c)
            SRC_PIN_RISE: r = e.rise;
            SRC_PIN_FALL: r = e.fall;
            SRC_PIN_BOTH: r = e.rise | e.fall;
            default:      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tbase_div_en.sv
module tbase_div_en #(
    parameter int unsigned CW = 3
) (
    input  logic clk,
    input  logic rst,
    output logic div_en
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    // Terminal count: the counter wraps to zero on the next edge.
    assign div_en = &cnt_q;
endmodule

// File: rtl/tbase_edge_det.sv
module tbase_edge_det
    import tbase_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    output pin_evt_t evt
);
    logic prev_q;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            vld_q  <= 1'b1;
        end
    end

    // No edge is reported until a first sample exists after reset.
    always_comb begin
        evt.rise = vld_q & lvl & ~prev_q;
        evt.fall = vld_q & ~lvl & prev_q;
    end
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic [W-1:0] div_val,
    output logic         carry
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim;

    always_comb begin
        if (div_val <= W'(1)) lim = '0;
        else                  lim = div_val - W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            carry <= 1'b0;
        end else begin
            carry <= 1'b0;
            if (inc) begin
                if (cnt_q >= lim) begin
                    cnt_q <= '0;
                    carry <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tbase_src_sel.sv
module tbase_src_sel
    import tbase_sel_pkg::*;
#(
    parameter int unsigned PS_W  = 8,
    parameter int unsigned DIV_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_lvl,
    input  logic [2:0]      src_code,
    input  logic            angle_en,
    input  logic [PS_W-1:0] div_val,
    output logic            pre_tick,
    output logic            cnt_tick,
    output logic            tooth_tick
);
    src_code_e code_q;
    logic      angle_q;
    logic      div_en;
    pin_evt_t  evt;
    logic      adv_req;
    logic      tooth_req;
    logic      pre_q;
    logic      tooth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= SRC_RESET;
            angle_q <= 1'b0;
        end else begin
            code_q  <= src_code_e'(src_code);
            angle_q <= angle_en;
        end
    end

    tbase_div_en #(.CW(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .div_en (div_en)
    );

    tbase_edge_det u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (ext_lvl),
        .evt (evt)
    );

    always_comb begin
        adv_req   = ~angle_q & pick_advance(code_q, div_en, ext_lvl, evt);
        tooth_req = angle_q & pick_tooth(code_q, evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= 1'b0;
            tooth_q <= 1'b0;
        end else begin
            pre_q   <= adv_req;
            tooth_q <= tooth_req;
        end
    end

    tbase_prescaler #(.W(PS_W)) u_ps (
        .clk     (clk),
        .rst     (rst),
        .inc     (pre_q),
        .div_val (div_val),
        .carry   (cnt_tick)
    );

    assign pre_tick   = pre_q;
    assign tooth_tick = tooth_q;
endmodule

// File: rtl/tbase_src_sel_chk.sv
module tbase_src_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       pre_tick,
    input logic       cnt_tick,
    input logic       tooth_tick,
    input logic [2:0] code_q,
    input logic       angle_q
);
    p_reset_code_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ($past(code_q) == 3'b001));

    p_quiet_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(code_q) >= 3'b101 && !$past(angle_q)) |-> !pre_tick);

    p_no_pre_angle_r6: assert property (@(posedge clk) disable iff (rst)
        $past(angle_q) |-> !pre_tick);

    p_no_tooth_off_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(angle_q) |-> !tooth_tick);

    p_carry_after_pre_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_tick |-> $past(pre_tick));

    p_free_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (pre_tick && $past(code_q) == 3'b100 && $past(code_q, 2) == 3'b100
         && !$past(angle_q)) |=> !pre_tick);
endmodule

bind tbase_src_sel tbase_src_sel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pre_tick   (pre_tick),
    .cnt_tick   (cnt_tick),
    .tooth_tick (tooth_tick),
    .code_q     (code_q),
    .angle_q    (angle_q)
);

// File: tb/tbase_src_sel_tb.sv
module tbase_src_sel_tb;
    localparam int PS_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ext_lvl = 1'b0;
    logic [2:0]      src_code = 3'b100;
    logic            angle_en = 1'b0;
    logic [PS_W-1:0] div_val = 8'd1;
    logic            pre_tick, cnt_tick, tooth_tick;

    int n_chk = 0;
    int n_fail = 0;
    int n_pre = 0;
    int n_tooth = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tbase_src_sel #(.PS_W(PS_W)) u_dut (
        .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .src_code(src_code),
        .angle_en(angle_en), .div_val(div_val), .pre_tick(pre_tick),
        .cnt_tick(cnt_tick), .tooth_tick(tooth_tick)
    );

    typedef struct {
        logic  pre;
        logic  cnt;
        logic  tooth;
        string tp;
        string tt;
    } exp_t;
    exp_t sb_q[$];

    // Reference model state
    int   m_div = 0;
    logic m_prev = 0, m_vld = 0, m_ang = 0, m_pre = 0, m_tooth = 0, m_carry = 0;
    logic [2:0] m_code = 3'b001;
    int   m_ps = 0;

    task automatic check(string tag, int got, int exp_v);
        n_chk++;
        if (got != exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp_v, $time);
        end
    endtask

    // Model: advances on each edge from the inputs held since the last negedge.
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            m_div = 0; m_prev = 0; m_vld = 0; m_ang = 0; m_code = 3'b001;
            m_pre = 0; m_tooth = 0; m_ps = 0; m_carry = 0;
            e.tp = "R1"; e.tt = "R1";
        end else begin
            logic de, rise, fall, sel, tsel;
            int lim;
            de   = (m_div == 7);
            rise = m_vld & ext_lvl & ~m_prev;
            fall = m_vld & ~ext_lvl & m_prev;
            case (m_code)
                3'd0: sel = de & ext_lvl;
                3'd1: sel = rise;
                3'd2: sel = fall;
                3'd3: sel = rise | fall;
                3'd4: sel = de;
                default: sel = 0;
            endcase
            case (m_code)
                3'd1: tsel = rise;
                3'd2: tsel = fall;
                3'd3: tsel = rise | fall;
                default: tsel = 0;
            endcase
            if (m_ang) e.tp = "R6";
            else if (m_code == 0) e.tp = "R2";
            else if (m_code <= 3) e.tp = "R3";
            else if (m_code == 4) e.tp = "R4";
            else e.tp = "R5";
            e.tt = (m_ang && m_code >= 1 && m_code <= 3) ? "R6" : "R7";
            m_carry = 0;
            if (m_pre) begin
                lim = (div_val <= 1) ? 0 : int'(div_val) - 1;
                if (m_ps >= lim) begin m_ps = 0; m_carry = 1; end
                else m_ps++;
            end
            m_pre   = ~m_ang & sel;
            m_tooth = m_ang & tsel;
            m_div   = (m_div + 1) % 8;
            m_prev  = ext_lvl;
            m_vld   = 1;
            m_code  = src_code;
            m_ang   = angle_en;
        end
        e.pre = m_pre; e.cnt = m_carry; e.tooth = m_tooth;
        sb_q.push_back(e);
    end

    // Monitor: pops the expectation for this cycle and compares.
    always @(negedge clk) begin
        if (pre_tick) n_pre++;
        if (tooth_tick) n_tooth++;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tp, " pre_tick"}, int'(pre_tick), int'(e.pre));
            check("R8 cnt_tick", int'(cnt_tick), int'(e.cnt));
            check({e.tt, " tooth_tick"}, int'(tooth_tick), int'(e.tooth));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_pin(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ext_lvl = 1'($urandom_range(0, 1));
        end
    endtask

    initial begin
        cyc(4);
        // R1: reset state of the outputs
        check("R1 pre_tick in reset", int'(pre_tick), 0);
        check("R1 tooth_tick in reset", int'(tooth_tick), 0);
        check("R1 cnt_tick in reset", int'(cnt_tick), 0);
        rst = 1'b0;

        // R4: free-running divide-by-8, 80-cycle window
        cyc(3);
        n_pre = 0;
        rand_pin(80);
        check("R4 pulses in 80 cycles", n_pre, 10);

        // R2: gated divide-by-8, random pin and long plateaus; R8 with div 2
        src_code = 3'b000; div_val = 8'd2;
        rand_pin(120);
        ext_lvl = 1'b0; cyc(3); n_pre = 0; cyc(40);
        check("R2 no pulses with pin low", n_pre, 0);
        ext_lvl = 1'b1; cyc(2); n_pre = 0; cyc(40);
        check("R2 pulses with pin high", n_pre, 5);

        // R3: edge codes, various divide values
        for (int c = 1; c <= 3; c++) begin
            src_code = 3'(c); div_val = 8'(c + 1);
            rand_pin(100);
        end

        // R9: single rise held high gives one strobe
        src_code = 3'b001; ext_lvl = 1'b0; cyc(4);
        n_pre = 0; ext_lvl = 1'b1; cyc(30);
        check("R9 one strobe per edge", n_pre, 1);

        // R5: reserved and halt codes
        for (int c = 5; c <= 7; c++) begin
            src_code = 3'(c); cyc(2); n_pre = 0;
            rand_pin(60);
            check("R5 no pulses", n_pre, 0);
        end

        // R6/R7: angle mode across all codes
        angle_en = 1'b1;
        for (int c = 0; c < 8; c++) begin
            src_code = 3'(c);
            rand_pin(60);
        end
        src_code = 3'b011; ext_lvl = 1'b0; cyc(4);
        n_pre = 0; n_tooth = 0;
        for (int i = 0; i < 10; i++) begin
            ext_lvl = ~ext_lvl; cyc(3);
        end
        cyc(3);
        check("R6 tooth count both edges", n_tooth, 10);
        check("R6 no pre_tick in angle mode", n_pre, 0);
        src_code = 3'b100; cyc(2); n_tooth = 0;
        rand_pin(50);
        check("R7 no tooth for code 100", n_tooth, 0);

        // R8: divide 0 and 5 with free-running source
        angle_en = 1'b0; src_code = 3'b100;
        div_val = 8'd0; rand_pin(64);
        div_val = 8'd5; rand_pin(200);

        // R1: reset mid-run
        rst = 1'b1; cyc(3);
        check("R1 pre_tick low in reset", int'(pre_tick), 0);
        rst = 1'b0; rand_pin(40);

        cyc(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule